// File: doc/BRIEF.md
# Synchronizable PWM Time-Base Counter

This block is the timing heart of one PWM channel. A 16-bit counter advances once per prescaled tick. The tick rate is the system clock divided by the product of two programmable factors. The counter runs in one of four modes:

- counting up and wrapping to zero,
- counting down and wrapping to the period value,
- counting up and down between zero and the period value,
- frozen.

Comparators against zero, the period value and two compare values give the event flags that the waveform logic of the channel decodes. The current count direction is also brought out.

Several instances can be chained to run as one system. A sync pulse, taken from an external input or forced by software, reloads the counter with a phase value. In up-down mode it also sets the direction the counter takes after the load. A selectable sync output passes on either the incoming sync, the zero-match or the compare-B match, so that the next instance in a chain can lock to this one. A sticky flag records that a sync pulse arrived. All configuration comes in on plain input ports.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is asserted, the count is 0, the direction output is 1 (counting up) and the sync flag is 0.
- R2: The counter moves at most once per tick. A tick occurs every D system clocks, with D = 2^clk_div_i × H. H is 1 when hs_div_i is 0 and 2 × hs_div_i otherwise, so encoding 001 divides by 2. A sync load restarts the tick timing.
- R3: With mode_i = 00 (up), each tick takes the count to count+1. A count at or above period_i goes to 0 instead, so a period lasts period_i+1 ticks. The direction output is 1.
- R4: With mode_i = 01 (down), each tick takes the count to count−1. A count of 0 goes to period_i instead. The direction output is 0.
- R5: With mode_i = 10 (up-down), the counter climbs to period_i and then descends to 0. It reverses at each end, so one period lasts 2 × period_i ticks. The direction output is 1 while climbing.
- R6: With mode_i = 11 (frozen), ticks leave the count and the direction unchanged.
- R7: When phase_en_i is 1, a sync event (sync_i OR swsync_i) loads phase_i into the count at the next clock edge, in any mode. When phase_en_i is 0, sync events leave the count unchanged.
- R8: A sync load sets the direction output as follows. In up-down mode it takes the value of phase_dir_i (1 = up). In up mode it is 1, in down mode it is 0, and in frozen mode it is unchanged.
- R9: zero_o, prd_o, cmpa_o and cmpb_o are 1 exactly while the count equals 0, period_i, cmpa_i and cmpb_i respectively.
- R10: sync_o depends on synco_sel_i as follows:
  - 00: sync_i OR swsync_i, passed straight through.
  - 01: zero_o, but only in the clock after the counter was written.
  - 10: cmpb_o, but only in the clock after the counter was written.
  - 11: always 0.
- R11: sync_flag_o goes to 1 in the clock after any sync event, whatever phase_en_i is. It holds until sync_clr_i clears it, and a sync event in the same clock as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Count mode: 00 up, 01 down, 10 up-down, 11 frozen |
| clk_div_i | input | 3 | Power-of-two prescale exponent |
| hs_div_i | input | 3 | Second prescale field (0 means ÷1, n means ÷2n) |
| period_i | input | 16 | Period value |
| phase_i | input | 16 | Value loaded on a sync event |
| phase_en_i | input | 1 | Enables phase loading on sync |
| phase_dir_i | input | 1 | Direction after a sync load in up-down mode (1 = up) |
| cmpa_i | input | 16 | Compare A value |
| cmpb_i | input | 16 | Compare B value |
| sync_i | input | 1 | External sync pulse |
| swsync_i | input | 1 | Software-forced sync pulse |
| synco_sel_i | input | 2 | Sync output source select |
| sync_clr_i | input | 1 | Clears the sync flag |
| count_o | output | 16 | Current count |
| dir_o | output | 1 | Current direction (1 = up) |
| zero_o | output | 1 | Count equals zero |
| prd_o | output | 1 | Count equals period |
| cmpa_o | output | 1 | Count equals compare A |
| cmpb_o | output | 1 | Count equals compare B |
| sync_o | output | 1 | Sync output for chaining |
| sync_flag_o | output | 1 | Sticky sync-seen flag |

## Verification
The counter is exercised in each mode with a short period, at division 1, at small composite divisions and at the largest division, so that wrap values, turning points and tick spacing can be told apart. Sync pulses are sent from both sources:

- with phase loading on and off,
- with both direction choices in up-down mode,
- with a phase above the period.

These separate a correct load from an ignored one and show the direction taken after a load. Every sync output selection is visited while matches occur. The flag is cleared both alone and in the same clock as a new sync, which checks that a sync wins over a clear.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  localparam int unsigned PRE_W   = 3;
  localparam int unsigned MAX_DIV = (1 << ((1 << PRE_W) - 1)) * (2 * ((1 << PRE_W) - 1));
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);

  typedef enum logic [1:0] {
    CM_UP     = 2'b00,
    CM_DOWN   = 2'b01,
    CM_UPDOWN = 2'b10,
    CM_FREEZE = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SO_PASS = 2'b00,
    SO_ZERO = 2'b01,
    SO_CMPB = 2'b10,
    SO_OFF  = 2'b11
  } sync_src_e;

  // System clocks per tick for the two prescale fields.
  function automatic int unsigned tick_divisor(input logic [PRE_W-1:0] cd,
                                               input logic [PRE_W-1:0] hs);
    int unsigned h;
    h = (hs == '0) ? 32'd1 : 32'd2 * 32'(hs);
    return (32'd1 << cd) * h;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_tb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] clk_div_i,
  input  logic [PRE_W-1:0] hs_div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] pc_q;
  logic [DIV_W-1:0] limit;

  assign limit  = DIV_W'(tick_divisor(clk_div_i, hs_div_i) - 32'd1);
  assign tick_o = (pc_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pc_q <= '0;
    else if (restart_i || tick_o) pc_q <= '0;
    else                      pc_q <= pc_q + DIV_W'(1);
  end

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
  import pwm_tb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             phase_dir_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             upd_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d, upd_q, upd_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    upd_d = 1'b0;
    if (load_i) begin
      cnt_d = phase_i;
      upd_d = 1'b1;
      case (mode_i)
        CM_UP:     dir_d = 1'b1;
        CM_DOWN:   dir_d = 1'b0;
        CM_UPDOWN: dir_d = phase_dir_i;
        default:   dir_d = dir_q;
      endcase
    end else if (tick_i && mode_i != CM_FREEZE) begin
      upd_d = 1'b1;
      case (mode_i)
        CM_UP: begin
          dir_d = 1'b1;
          cnt_d = (cnt_q >= period_i) ? '0 : cnt_q + CNT_W'(1);
        end
        CM_DOWN: begin
          dir_d = 1'b0;
          cnt_d = (cnt_q == '0) ? period_i : cnt_q - CNT_W'(1);
        end
        default: begin
          if (dir_q) begin
            if (cnt_q >= period_i) begin
              dir_d = 1'b0;
              cnt_d = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end else begin
            if (cnt_q == '0) begin
              dir_d = 1'b1;
              cnt_d = (period_i == '0) ? '0 : CNT_W'(1);
            end else begin
              cnt_d = cnt_q - CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      upd_q <= upd_d;
    end
  end

  assign count_o = cnt_q;
  assign dir_o   = dir_q;
  assign upd_o   = upd_q;

endmodule

// File: rtl/pwm_event_unit.sv
module pwm_event_unit
  import pwm_tb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmpa_i,
  input  logic [CNT_W-1:0] cmpb_i,
  input  logic             upd_i,
  input  logic             sync_evt_i,
  input  logic             sync_clr_i,
  input  sync_src_e        sel_i,
  output logic             zero_o,
  output logic             prd_o,
  output logic             cmpa_o,
  output logic             cmpb_o,
  output logic             sync_o,
  output logic             sync_flag_o
);

  logic flag_q;

  assign zero_o = (count_i == '0);
  assign prd_o  = (count_i == period_i);
  assign cmpa_o = (count_i == cmpa_i);
  assign cmpb_o = (count_i == cmpb_i);

  always_comb begin
    case (sel_i)
      SO_PASS: sync_o = sync_evt_i;
      SO_ZERO: sync_o = zero_o & upd_i;
      SO_CMPB: sync_o = cmpb_o & upd_i;
      default: sync_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (sync_evt_i) flag_q <= 1'b1;
    else if (sync_clr_i) flag_q <= 1'b0;
  end

  assign sync_flag_o = flag_q;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [2:0]       clk_div_i,
  input  logic [2:0]       hs_div_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             phase_en_i,
  input  logic             phase_dir_i,
  input  logic [CNT_W-1:0] cmpa_i,
  input  logic [CNT_W-1:0] cmpb_i,
  input  logic             sync_i,
  input  logic             swsync_i,
  input  logic [1:0]       synco_sel_i,
  input  logic             sync_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             zero_o,
  output logic             prd_o,
  output logic             cmpa_o,
  output logic             cmpb_o,
  output logic             sync_o,
  output logic             sync_flag_o
);

  // Named internal events, visible to the bound checker.
  logic tick;
  logic sync_evt;
  logic sync_load;
  logic upd;

  assign sync_evt  = sync_i | swsync_i;
  assign sync_load = sync_evt & phase_en_i;

  pwm_prescaler u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (sync_load),
    .clk_div_i (clk_div_i),
    .hs_div_i  (hs_div_i),
    .tick_o    (tick)
  );

  pwm_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .load_i      (sync_load),
    .mode_i      (cnt_mode_e'(mode_i)),
    .period_i    (period_i),
    .phase_i     (phase_i),
    .phase_dir_i (phase_dir_i),
    .count_o     (count_o),
    .dir_o       (dir_o),
    .upd_o       (upd)
  );

  pwm_event_unit #(.CNT_W(CNT_W)) u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_i     (count_o),
    .period_i    (period_i),
    .cmpa_i      (cmpa_i),
    .cmpb_i      (cmpb_i),
    .upd_i       (upd),
    .sync_evt_i  (sync_evt),
    .sync_clr_i  (sync_clr_i),
    .sel_i       (sync_src_e'(synco_sel_i)),
    .zero_o      (zero_o),
    .prd_o       (prd_o),
    .cmpa_o      (cmpa_o),
    .cmpb_o      (cmpb_o),
    .sync_o      (sync_o),
    .sync_flag_o (sync_flag_o)
  );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] period_i,
  input logic [CNT_W-1:0] phase_i,
  input logic             phase_en_i,
  input logic             phase_dir_i,
  input logic             sync_i,
  input logic             swsync_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_o,
  input logic             sync_flag_o,
  input logic             tick
);

  logic ld;
  assign ld = (sync_i | swsync_i) & phase_en_i;

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && !ld) |=> $stable(count_o));

  // R7
  phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (count_o == $past(phase_i)));

  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && tick && !ld && count_o >= period_i) |=> (count_o == '0));

  // R8
  sync_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && mode_i == 2'b10) |=> (dir_o == $past(phase_dir_i)));

  // R11
  sync_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i | swsync_i) |=> sync_flag_o);

  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(count_o));

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .period_i    (period_i),
  .phase_i     (phase_i),
  .phase_en_i  (phase_en_i),
  .phase_dir_i (phase_dir_i),
  .sync_i      (sync_i),
  .swsync_i    (swsync_i),
  .count_o     (count_o),
  .dir_o       (dir_o),
  .sync_flag_o (sync_flag_o),
  .tick        (tick)
);

// File: tb/tb_pwm_timebase.sv
`timescale 1ns/1ps
module tb_pwm_timebase;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b11;
  logic [2:0]  clk_div_i = 3'd0, hs_div_i = 3'd0;
  logic [15:0] period_i = 16'd5, phase_i = 16'd0, cmpa_i = 16'd0, cmpb_i = 16'd0;
  logic        phase_en_i = 1'b0, phase_dir_i = 1'b0;
  logic        sync_i = 1'b0, swsync_i = 1'b0, sync_clr_i = 1'b0;
  logic [1:0]  synco_sel_i = 2'b11;
  logic [15:0] count_o;
  logic        dir_o, zero_o, prd_o, cmpa_o, cmpb_o, sync_o, sync_flag_o;

  int compared = 0, mismatched = 0, cycles = 0;
  bit chk_en = 1'b0;

  // behavioural reference state
  int m_cnt, m_pc;
  bit m_dir, m_upd, m_flag, m_last_load;

  always #5 clk = ~clk;

  pwm_timebase dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .clk_div_i(clk_div_i), .hs_div_i(hs_div_i),
    .period_i(period_i), .phase_i(phase_i), .phase_en_i(phase_en_i), .phase_dir_i(phase_dir_i),
    .cmpa_i(cmpa_i), .cmpb_i(cmpb_i), .sync_i(sync_i), .swsync_i(swsync_i),
    .synco_sel_i(synco_sel_i), .sync_clr_i(sync_clr_i), .count_o(count_o), .dir_o(dir_o),
    .zero_o(zero_o), .prd_o(prd_o), .cmpa_o(cmpa_o), .cmpb_o(cmpb_o), .sync_o(sync_o),
    .sync_flag_o(sync_flag_o)
  );

  // Reference model: advances on every rising edge from the inputs alone.
  always @(posedge clk) begin
    int div, p;
    bit sync, tick;
    if (!rst_n) begin
      m_cnt = 0; m_pc = 0; m_dir = 1; m_upd = 0; m_flag = 0; m_last_load = 0;
    end else begin
      p    = period_i;
      sync = sync_i || swsync_i;
      div  = (2 ** clk_div_i) * ((hs_div_i == 0) ? 1 : 2 * hs_div_i);
      tick = (m_pc >= div - 1);
      m_upd = 0;
      if (sync && phase_en_i) begin
        m_cnt = phase_i; m_pc = 0; m_upd = 1; m_last_load = 1;
        if (mode_i == 0) m_dir = 1;
        else if (mode_i == 1) m_dir = 0;
        else if (mode_i == 2) m_dir = phase_dir_i;
      end else begin
        m_pc = tick ? 0 : m_pc + 1;
        if (tick && mode_i != 3) begin
          m_upd = 1; m_last_load = 0;
          if (mode_i == 0) begin
            m_dir = 1;
            m_cnt = (m_cnt >= p) ? 0 : m_cnt + 1;
          end else if (mode_i == 1) begin
            m_dir = 0;
            m_cnt = (m_cnt == 0) ? p : m_cnt - 1;
          end else if (m_dir) begin
            if (m_cnt >= p) begin m_dir = 0; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
            else m_cnt = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin m_dir = 1; m_cnt = (p == 0) ? 0 : 1; end
            else m_cnt = m_cnt - 1;
          end
        end
      end
      if (sync) m_flag = 1;
      else if (sync_clr_i) m_flag = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare away from the active edge.
  always @(negedge clk) begin
    string ctag;
    bit exp_sync;
    if (chk_en) begin
      if (!rst_n) begin
        check("R1 count", count_o, 0);
        check("R1 dir", dir_o, 1);
        check("R1 flag", sync_flag_o, 0);
      end else begin
        ctag = m_last_load ? "R7 count" :
               (mode_i == 0) ? "R2 R3 count" : (mode_i == 1) ? "R2 R4 count" :
               (mode_i == 2) ? "R2 R5 count" : "R6 count";
        check(ctag, count_o, m_cnt);
        check(m_last_load ? "R8 dir" : "R5 dir", dir_o, m_dir);
        check("R9 zero", zero_o, m_cnt == 0);
        check("R9 prd", prd_o, m_cnt == period_i);
        check("R9 cmpa", cmpa_o, m_cnt == cmpa_i);
        check("R9 cmpb", cmpb_o, m_cnt == cmpb_i);
        case (synco_sel_i)
          2'b00: exp_sync = sync_i || swsync_i;
          2'b01: exp_sync = (m_cnt == 0) && m_upd;
          2'b10: exp_sync = (m_cnt == cmpb_i) && m_upd;
          default: exp_sync = 0;
        endcase
        check("R10 sync_o", sync_o, exp_sync);
        check("R11 flag", sync_flag_o, m_flag);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic pulse_sync(input bit sw);
    if (sw) swsync_i = 1; else sync_i = 1;
    step(1);
    sync_i = 0; swsync_i = 0;
  endtask

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        mismatched++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        finish_up();
      end
    end
  end

  initial begin
    chk_en = 1;
    step(3);                       // R1 checked during reset
    rst_n = 1; step(4);            // frozen after reset: R6
    // R3 up, divide 1
    cmpa_i = 2; cmpb_i = 4; synco_sel_i = 2'b01; mode_i = 2'b00; step(20);
    // R2 divide 4 (clk_div 1, hs 001 = /2), then 12
    clk_div_i = 1; hs_div_i = 1; synco_sel_i = 2'b10; step(60);
    clk_div_i = 1; hs_div_i = 3; step(100);
    clk_div_i = 0; hs_div_i = 0;
    // R4 down
    mode_i = 2'b01; period_i = 4; synco_sel_i = 2'b00; step(20);
    // R5 up-down with turning points
    mode_i = 2'b10; synco_sel_i = 2'b01; step(30);
    // R7/R8 sync loads in up-down, both directions, both sources
    phase_en_i = 1; phase_i = 2; phase_dir_i = 0; pulse_sync(0); step(6);
    phase_dir_i = 1; phase_i = 3; pulse_sync(1); step(6);
    synco_sel_i = 2'b00; pulse_sync(0); step(3);
    // phase above the period
    phase_i = 9; pulse_sync(0); step(8);
    // R7 ignored when disabled
    phase_en_i = 0; phase_i = 1; pulse_sync(0); step(5);
    // R11 clear, then clear with simultaneous sync
    sync_clr_i = 1; step(1); sync_clr_i = 0; step(2);
    sync_clr_i = 1; swsync_i = 1; step(1); sync_clr_i = 0; swsync_i = 0; step(2);
    sync_clr_i = 1; step(1); sync_clr_i = 0;
    // R7 load in up and down modes, R10 off
    synco_sel_i = 2'b11; phase_en_i = 1; mode_i = 2'b00; phase_i = 1; pulse_sync(1); step(6);
    mode_i = 2'b01; phase_i = 3; pulse_sync(0); step(6);
    // R6 freeze with ticks, then load while frozen
    mode_i = 2'b11; step(10); phase_i = 2; pulse_sync(0); step(5);
    // R2 largest division
    mode_i = 2'b00; clk_div_i = 7; hs_div_i = 7; synco_sel_i = 2'b01; step(6000);
    // period zero in up-down
    clk_div_i = 0; hs_div_i = 0; mode_i = 2'b10; period_i = 0; step(10);
    finish_up();
  end

endmodule